// File: doc/BRIEF.md
# Start-up Hold Sequencer

This block decides when the core may start running. It holds a `ready` output low after a block reset, after each reset-release event and after each entry into power-down. It raises `ready` only once the hold-off interval for that event has run out. The system clock enable is gated with `ready`. The block runs on the oscillator clock. Short hold-offs are counted in oscillator cycles. Long hold-offs count pulses of an external one-millisecond tick.

There are two recipes. A reset release always waits a fixed number of oscillator cycles. It may then add a millisecond wait, chosen by a 2-bit start-up code. That code is captured only while the block reset `rst_n` is low, and the core sees it as static. A wake from power-down waits a short oscillator-cycle count. It then adds a further halt of a few cycles before the core resumes. The reserved code value is treated as the longest wait, so a bad setting errs toward safety.

Top module: `startup_hold_seq`

## Requirements
- R1: After `rst_n` is released, `ready` stays low until a `rst_release` pulse is sampled. Pulses on `ms_tick`, `pd_enter` or `wake_pd` before that have no effect.
- R2: With start-up code 2'b00 latched, `ready` rises on the 14th rising clock edge after the edge that samples `rst_release`.
- R3: With code 2'b01, the 14-cycle wait is followed by a wait for 4 `ms_tick` pulses. `ready` rises on the edge that samples the 4th counted pulse.
- R4: With code 2'b10, the 14-cycle wait is followed by a wait for 64 counted `ms_tick` pulses.
- R5: Code 2'b11 behaves exactly as code 2'b10: 14 cycles, then 64 counted pulses.
- R6: `sut_code` is sampled on rising edges while `rst_n` is low. Changing it while `rst_n` is high does not change any hold-off.
- R7: Only `ms_tick` pulses sampled after the cycle wait has ended are counted. A pulse sampled on the edge that ends the cycle wait is not counted.
- R8: A `pd_enter` pulse sampled while `ready` is high drives `ready` low on that edge. `ready` then stays low until a wake or a reset release.
- R9: A `wake_pd` pulse sampled in power-down raises `ready` on the 10th edge after it. This is 6 wake cycles plus 4 halt cycles, and millisecond ticks play no part.
- R10: A `rst_release` pulse sampled in any state drives `ready` low and restarts the reset recipe from the beginning. It takes priority over `pd_enter` and `wake_pd` sampled on the same edge.
- R11: `wake_pd` has no effect unless the block is in power-down. `pd_enter` has no effect unless `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low block reset. `sut_code` is captured while it is low |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| sut_code | input | 2 | Start-up code: 00 none, 01 short, 10 long, 11 treated as long |
| rst_release | input | 1 | One-cycle pulse marking the release of a system reset |
| pd_enter | input | 1 | One-cycle pulse marking entry into power-down |
| wake_pd | input | 1 | One-cycle pulse marking a wake-up from power-down |
| ready | output | 1 | High when the system clock may run |

## Verification
All four start-up codes are run with the tick pulsing every third cycle, including during the cycle wait. Comparing the release cycle for code 00 with the release cycles for codes 01, 10 and 11 separates the cycle count from the tick count. It also shows whether ticks arriving too early are wrongly counted. After reset the code input is changed. This shows whether the value latched in reset or the live value is used. Power-down and wake pulses are placed in the waiting state, while running and while asleep, and a reset release is placed on the same edge as a power-down request and in the middle of a millisecond wait. These cases check the priority order and the ignore rules.

// File: rtl/shs_pkg.sv
package shs_pkg;

  typedef enum logic [2:0] {
    PH_HOLD  = 3'd0,
    PH_CYC   = 3'd1,
    PH_HALT  = 3'd2,
    PH_MS    = 3'd3,
    PH_RUN   = 3'd4,
    PH_SLEEP = 3'd5
  } shs_phase_e;

  // Millisecond count for a start-up code; the reserved code fails safe to the long wait.
  function automatic int unsigned ms_of_code(input logic [1:0] code,
                                             input int unsigned short_ms,
                                             input int unsigned long_ms);
    case (code)
      2'b00:   return 0;
      2'b01:   return short_ms;
      default: return long_ms;
    endcase
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/shs_code_latch.sv
module shs_code_latch #(
  parameter int unsigned MS_SHORT = 4,
  parameter int unsigned MS_LONG  = 64,
  parameter int unsigned MS_W     = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      code_in,
  output logic [MS_W-1:0] ms_need
);
  import shs_pkg::*;

  logic [1:0] code_q;

  // Captured only while the block is held in reset
  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= code_in;
  end

  assign ms_need = MS_W'(ms_of_code(code_q, MS_SHORT, MS_LONG));

endmodule

// File: rtl/shs_cyc_timer.sv
module shs_cyc_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;
  logic         busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val - W'(1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - W'(1);
    end
  end

  // Final cycle of the loaded interval
  assign done = busy_q && (cnt_q == '0);

endmodule

// File: rtl/shs_ms_timer.sv
module shs_ms_timer #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         done
);
  logic [W-1:0] left_q;
  logic         busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (clr) begin
      busy_q <= 1'b0;
    end else if (load) begin
      left_q <= load_val;
      busy_q <= 1'b1;
    end else if (busy_q && tick) begin
      if (left_q == W'(1)) busy_q <= 1'b0;
      else                 left_q <= left_q - W'(1);
    end
  end

  assign done = busy_q && tick && (left_q == W'(1));

endmodule

// File: rtl/startup_hold_seq.sv
module startup_hold_seq #(
  parameter int unsigned RST_CYC  = 14,
  parameter int unsigned WAKE_CYC = 6,
  parameter int unsigned HALT_CYC = 4,
  parameter int unsigned MS_SHORT = 4,
  parameter int unsigned MS_LONG  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic [1:0] sut_code,
  input  logic       rst_release,
  input  logic       pd_enter,
  input  logic       wake_pd,
  output logic       ready
);
  import shs_pkg::*;

  localparam int unsigned CYC_MAX = max_of(RST_CYC, max_of(WAKE_CYC, HALT_CYC));
  localparam int unsigned CYC_W   = $clog2(CYC_MAX + 1);
  localparam int unsigned MS_W    = $clog2(max_of(MS_SHORT, MS_LONG) + 1);

  shs_phase_e      phase_q, phase_d;
  logic            wake_path_q, wake_path_d;
  logic            cyc_load;
  logic [CYC_W-1:0] cyc_val;
  logic            ms_load;
  logic            ms_clr;
  logic [MS_W-1:0] ms_need;

  // Named events for the checker
  logic start_rst, start_wake, pd_go, sleeping, cyc_done, ms_done;

  assign sleeping   = (phase_q == PH_SLEEP);
  assign start_rst  = rst_release;
  assign start_wake = !rst_release && sleeping && wake_pd;
  assign pd_go      = !rst_release && (phase_q == PH_RUN) && pd_enter;

  shs_code_latch #(
    .MS_SHORT(MS_SHORT), .MS_LONG(MS_LONG), .MS_W(MS_W)
  ) u_code (
    .clk(clk), .rst_n(rst_n), .code_in(sut_code), .ms_need(ms_need)
  );

  shs_cyc_timer #(.W(CYC_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .load(cyc_load), .load_val(cyc_val), .done(cyc_done)
  );

  shs_ms_timer #(.W(MS_W)) u_ms (
    .clk(clk), .rst_n(rst_n), .clr(ms_clr), .load(ms_load),
    .load_val(ms_need), .tick(ms_tick), .done(ms_done)
  );

  always_comb begin
    phase_d     = phase_q;
    wake_path_d = wake_path_q;
    cyc_load    = 1'b0;
    cyc_val     = '0;
    ms_load     = 1'b0;
    ms_clr      = 1'b0;
    if (start_rst) begin
      phase_d     = PH_CYC;
      wake_path_d = 1'b0;
      cyc_load    = 1'b1;
      cyc_val     = CYC_W'(RST_CYC);
      ms_clr      = 1'b1;
    end else begin
      case (phase_q)
        PH_HOLD: phase_d = PH_HOLD;
        PH_CYC: begin
          if (cyc_done) begin
            if (wake_path_q) begin
              phase_d  = PH_HALT;
              cyc_load = 1'b1;
              cyc_val  = CYC_W'(HALT_CYC);
            end else if (ms_need == '0) begin
              phase_d = PH_RUN;
            end else begin
              phase_d = PH_MS;
              ms_load = 1'b1;
            end
          end
        end
        PH_HALT:  if (cyc_done) phase_d = PH_RUN;
        PH_MS:    if (ms_done)  phase_d = PH_RUN;
        PH_RUN:   if (pd_go)    phase_d = PH_SLEEP;
        PH_SLEEP: begin
          if (start_wake) begin
            phase_d     = PH_CYC;
            wake_path_d = 1'b1;
            cyc_load    = 1'b1;
            cyc_val     = CYC_W'(WAKE_CYC);
          end
        end
        default: phase_d = PH_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_HOLD;
      wake_path_q <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      wake_path_q <= wake_path_d;
    end
  end

  assign ready = (phase_q == PH_RUN);

endmodule

// File: rtl/shs_chk.sv
module shs_chk #(
  parameter int unsigned RST_CYC  = 14,
  parameter int unsigned WAKE_CYC = 6,
  parameter int unsigned HALT_CYC = 4,
  parameter int unsigned MS_W     = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ready,
  input logic            rst_release,
  input logic            pd_enter,
  input logic            wake_pd,
  input logic            start_rst,
  input logic            start_wake,
  input logic [MS_W-1:0] ms_need
);
  logic        seen_q;
  logic        kind_q;
  logic [15:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      kind_q  <= 1'b0;
      since_q <= '0;
    end else begin
      if (start_rst) seen_q <= 1'b1;
      if (start_rst) begin
        kind_q  <= 1'b0;
        since_q <= '0;
      end else if (start_wake) begin
        kind_q  <= 1'b1;
        since_q <= '0;
      end else if (since_q != 16'hFFFF) begin
        since_q <= since_q + 16'd1;
      end
    end
  end

  // R1
  hold_until_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !ready);

  // R2
  rst_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && !kind_q && ms_need == '0) |-> since_q == 16'(RST_CYC));

  // R3
  rst_ms_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && !kind_q) |-> since_q >= 16'(RST_CYC) + 16'(ms_need));

  // R6
  code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(ms_need));

  // R8
  pd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && pd_enter && !rst_release) |=> !ready);

  // R9
  wake_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && kind_q) |-> since_q == 16'(WAKE_CYC + HALT_CYC));

  // R10
  restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_release |=> !ready);

  // R11
  wake_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && wake_pd && !pd_enter && !rst_release) |=> ready);

endmodule

bind startup_hold_seq shs_chk #(
  .RST_CYC(RST_CYC), .WAKE_CYC(WAKE_CYC), .HALT_CYC(HALT_CYC), .MS_W(MS_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ready(ready), .rst_release(rst_release),
  .pd_enter(pd_enter), .wake_pd(wake_pd), .start_rst(start_rst),
  .start_wake(start_wake), .ms_need(ms_need)
);

// File: tb/startup_hold_seq_test.sv
`timescale 1ns/1ps
module startup_hold_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic [1:0] sut_code = 2'b00;
  logic       rst_release = 1'b0;
  logic       pd_enter = 1'b0;
  logic       wake_pd = 1'b0;
  logic       ready;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R1";
  logic tick_en = 1'b0;
  int tick_ph = 0;
  int tick_per = 3;

  always #5 clk = ~clk;

  startup_hold_seq uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sut_code(sut_code),
    .rst_release(rst_release), .pd_enter(pd_enter), .wake_pd(wake_pd), .ready(ready)
  );

  // Tick source
  always @(negedge clk) begin
    if (tick_en) begin
      tick_ph = tick_ph + 1;
      ms_tick = (tick_ph % tick_per == 0);
    end else begin
      ms_tick = 1'b0;
    end
  end

  // Reference model: remaining cycles, remaining ticks, and flags
  logic [1:0] m_code = 2'b00;
  bit m_ready = 0, m_sleep = 0, m_armed = 0;
  int m_wait = 0, m_ticks = 0;

  function automatic int ms_for(input logic [1:0] c);
    if (c == 2'b00) return 0;
    if (c == 2'b01) return 4;
    return 64;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code = sut_code;
      m_ready = 0; m_sleep = 0; m_armed = 0; m_wait = 0; m_ticks = 0;
    end else if (rst_release) begin
      m_ready = 0; m_sleep = 0; m_armed = 1; m_wait = 14; m_ticks = ms_for(m_code);
    end else if (m_armed) begin
      if (m_wait > 0) begin
        m_wait = m_wait - 1;
        if (m_wait == 0 && m_ticks == 0) begin m_ready = 1; m_armed = 0; end
      end else if (ms_tick) begin
        m_ticks = m_ticks - 1;
        if (m_ticks == 0) begin m_ready = 1; m_armed = 0; end
      end
    end else if (m_ready && pd_enter) begin
      m_ready = 0; m_sleep = 1;
    end else if (m_sleep && wake_pd) begin
      m_sleep = 0; m_armed = 1; m_wait = 10; m_ticks = 0;
    end
  end

  // Compare on every clock, shortly after the edge
  always begin
    @(posedge clk);
    #2;
    checks++;
    if (ready !== m_ready) begin
      fails++;
      $display("FAIL %s: per-cycle ready actual=%0d expected=%0d", cur_req, ready, m_ready);
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: cycles actual=%0d expected=%0d", cycles, 150000);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] code);
    @(negedge clk);
    sut_code = code;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    int n_long;
    tick_en = 1'b1;

    // R1: hold after reset, stray pulses ignored
    cur_req = "R1";
    do_reset(2'b00);
    chk(ready == 1'b0, "R1", "ready after reset", ready, 0);
    pulse(wake_pd);
    pulse(pd_enter);
    repeat (6) @(negedge clk);
    chk(ready == 1'b0, "R1", "ready before release", ready, 0);

    // R2: code 00, fixed cycles only
    cur_req = "R2";
    pulse(rst_release);
    wait_ready(n);
    chk(n == 14, "R2", "cycles to ready code 00", n, 14);

    // R11: wake while running does nothing
    cur_req = "R11";
    pulse(wake_pd);
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R11", "ready after stray wake", ready, 1);

    // R8: power-down drops ready
    cur_req = "R8";
    pulse(pd_enter);
    chk(ready == 1'b0, "R8", "ready after pd_enter", ready, 0);
    repeat (20) @(negedge clk);
    chk(ready == 1'b0, "R8", "ready while asleep", ready, 0);

    // R9: wake recipe
    cur_req = "R9";
    pulse(wake_pd);
    wait_ready(n);
    chk(n == 10, "R9", "cycles to ready after wake", n, 10);

    // R3 / R6 / R7: code 01, code changed after reset, ticks during cycle wait
    cur_req = "R3";
    do_reset(2'b01);
    sut_code = 2'b00;
    pulse(rst_release);
    wait_ready(n);
    chk(n >= 14 + 4 * tick_per - tick_per, "R7", "early ticks not counted", n, 14 + 3 * tick_per);
    chk(n != 14, "R6", "live code ignored", n, 15);
    chk(ready == 1'b1, "R3", "ready after short ms wait", ready, 1);

    // R4: long wait
    cur_req = "R4";
    do_reset(2'b10);
    pulse(rst_release);
    wait_ready(n_long);
    chk(n_long >= 14 + 63 * tick_per, "R4", "cycles to ready code 10", n_long, 14 + 63 * tick_per);
    chk(ready == 1'b1, "R4", "ready after long wait", ready, 1);

    // R5: reserved code fails safe
    cur_req = "R5";
    do_reset(2'b11);
    pulse(rst_release);
    wait_ready(n);
    chk(n >= 14 + 63 * tick_per, "R5", "cycles to ready code 11", n, 14 + 63 * tick_per);

    // R10: restart mid ms wait, and release beats pd_enter
    cur_req = "R10";
    do_reset(2'b01);
    pulse(rst_release);
    repeat (16) @(negedge clk);
    pulse(rst_release);
    chk(ready == 1'b0, "R10", "ready after restart", ready, 0);
    wait_ready(n);
    chk(n >= 14 + 3 * tick_per, "R10", "full recipe after restart", n, 14 + 3 * tick_per);
    @(negedge clk);
    rst_release = 1'b1;
    pd_enter = 1'b1;
    @(negedge clk);
    rst_release = 1'b0;
    pd_enter = 1'b0;
    chk(ready == 1'b0, "R10", "ready after release with pd", ready, 0);
    wait_ready(n);
    chk(ready == 1'b1, "R10", "reset recipe won over power-down", ready, 1);

    repeat (3) @(negedge clk);
    report();
  end

endmodule